// File: doc/BRIEF.md
# Partitioned SIMD Magnitude Comparator

This block compares two unsigned operands that are built from 8-bit lanes. Between each pair of neighbouring lanes sits a boundary that a run-time split vector opens or closes. Closed boundaries join neighbouring lanes into wider fields, so one datapath can serve as a single wide comparison, as a set of byte-wide comparisons, or as any mix of the two.

A two-bit operation code selects equality, unsigned greater-than or unsigned greater-or-equal. The result has one bit per lane. Every lane inside a joined group reports the comparison of that whole group. The block is purely combinational: there are no registers, and the result follows the inputs within the same cycle.

Inside a group, the higher lane is the more significant part of the joined value. Greater-than is formed by carrying per-lane greater and equal flags upward across closed boundaries, so no full-width subtractor is needed.

Top module: `pcmp_top`

## Requirements
- R1: Lanes are 8 bits wide. Lane i occupies bits [8i+7:8i] of each operand, and split bit j sits on the boundary between lane j and lane j+1, so LANES lanes have LANES-1 split bits.
- R2: Operation code 2'b00 gives equality: a lane's bit is 1 when its group's field in A equals the same field in B.
- R3: Operation code 2'b01 gives unsigned greater-than: a lane's bit is 1 when its group's field in A is strictly larger than in B.
- R4: Operation code 2'b10 gives unsigned greater-or-equal: a lane's bit is 1 when its group's field in A is larger than or equal to that in B.
- R5: With every split bit at 0, the whole operands are compared as single numbers and every result bit holds that one outcome.
- R6: Split bit 1 separates the two lanes beside it, and split bit 0 joins them. A group is compared on the concatenation of its lanes with the higher lane more significant, and every lane of the group carries that result.
- R7: With every split bit at 1, result bit i is the comparison of lane i of A with lane i of B alone.
- R8: With three lanes and split = 2'b01, bit 0 reflects lane 0 alone, and bits 1 and 2 both reflect lanes 2:1 joined. With split = 2'b10, bits 0 and 1 reflect lanes 1:0 joined and bit 2 reflects lane 2 alone.
- R9: Operation code 2'b11 is reserved and drives every result bit to 0, for any operands and split pattern.
- R10: The result is combinational: it reflects new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8*LANES | Operand A, lane 0 in the low byte |
| b_i | input | 8*LANES | Operand B, lane 0 in the low byte |
| op_i | input | 2 | Operation code: 00 equal, 01 greater, 10 greater-or-equal, 11 reserved |
| split_i | input | LANES-1 | Bit j at 1 opens the boundary between lane j and lane j+1 |
| res_o | output | LANES | One result bit per lane |

## Verification
The checker treats the block as combinational and checks only when no input bit is unknown. It relies on that condition because, with X on the operands or split bits, group membership and the flag carry are undefined. The bench always drives every input to a known value before it samples the result, including during the reset scenario. Its random patterns draw only from the four operation codes and the full range of the split vector, so each assertion's precondition is met in every case it covers.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
   localparam int unsigned LANE_BITS = 8;

   typedef enum logic [1:0] {
      OP_EQ  = 2'b00,
      OP_GT  = 2'b01,
      OP_GE  = 2'b10,
      OP_RSV = 2'b11
   } pcmp_op_e;

   typedef struct packed {
      logic gt;
      logic eq;
   } pcmp_flag_t;

   function automatic logic pick_result(input pcmp_flag_t f, input logic [1:0] op);
      logic r;
      case (op)
         OP_EQ:   r = f.eq;
         OP_GT:   r = f.gt;
         OP_GE:   r = f.gt | f.eq;
         default: r = 1'b0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pcmp_lane.sv
module pcmp_lane
   import pcmp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output pcmp_flag_t   flag_o
);
   always_comb begin
      flag_o.gt = (a_i > b_i);
      flag_o.eq = (a_i == b_i);
   end
endmodule

// File: rtl/pcmp_chain.sv
module pcmp_chain
   import pcmp_pkg::*;
#(
   parameter int unsigned LANES = 3
) (
   input  pcmp_flag_t [LANES-1:0] lane_i,
   input  logic       [LANES-2:0] split_i,
   output pcmp_flag_t [LANES-1:0] acc_o
);
   // acc at lane i: comparison of lanes from its group start up to lane i
   for (genvar i = 0; i < LANES; i++) begin : g_st
      pcmp_flag_t acc;
      if (i == 0) begin : g_base
         assign acc = lane_i[0];
      end else begin : g_link
         always_comb begin
            if (split_i[i-1]) begin
               acc = lane_i[i];
            end else begin
               acc.gt = lane_i[i].gt | (lane_i[i].eq & g_st[i-1].acc.gt);
               acc.eq = lane_i[i].eq & g_st[i-1].acc.eq;
            end
         end
      end
      assign acc_o[i] = acc;
   end
endmodule

// File: rtl/pcmp_spread.sv
module pcmp_spread
   import pcmp_pkg::*;
#(
   parameter int unsigned LANES = 3
) (
   input  pcmp_flag_t [LANES-1:0] acc_i,
   input  logic       [LANES-2:0] split_i,
   output pcmp_flag_t [LANES-1:0] grp_o
);
   // top lane of each group holds the group result; copy it downward
   for (genvar i = LANES - 1; i >= 0; i--) begin : g_sp
      pcmp_flag_t val;
      if (i == LANES - 1) begin : g_top
         assign val = acc_i[i];
      end else begin : g_mid
         assign val = split_i[i] ? acc_i[i] : g_sp[i+1].val;
      end
      assign grp_o[i] = val;
   end
endmodule

// File: rtl/pcmp_top.sv
module pcmp_top
   import pcmp_pkg::*;
#(
   parameter int unsigned LANES  = 3,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] a_i,
   input  logic [LANES*LANE_W-1:0] b_i,
   input  logic [1:0]              op_i,
   input  logic [LANES-2:0]        split_i,
   output logic [LANES-1:0]        res_o
);
   localparam int unsigned WIDTH = LANES * LANE_W;

   if (LANES < 2) begin : g_bad_lanes
      $error("pcmp_top: LANES must be at least 2");
   end
   if (LANE_W != LANE_BITS) begin : g_bad_width
      $error("pcmp_top: LANE_W must equal the fixed 8-bit lane size");
   end
   if (WIDTH > 1024) begin : g_bad_total
      $error("pcmp_top: operand width too large");
   end

   pcmp_flag_t [LANES-1:0] lane_f;
   pcmp_flag_t [LANES-1:0] acc_f;
   pcmp_flag_t [LANES-1:0] grp_f;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pcmp_lane #(.W(LANE_W)) u_lane (
         .a_i    (a_i[i*LANE_W +: LANE_W]),
         .b_i    (b_i[i*LANE_W +: LANE_W]),
         .flag_o (lane_f[i])
      );
   end

   pcmp_chain #(.LANES(LANES)) u_chain (
      .lane_i  (lane_f),
      .split_i (split_i),
      .acc_o   (acc_f)
   );

   pcmp_spread #(.LANES(LANES)) u_spread (
      .acc_i   (acc_f),
      .split_i (split_i),
      .grp_o   (grp_f)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_out
      assign res_o[i] = pick_result(grp_f[i], op_i);
   end
endmodule

// File: rtl/pcmp_check.sv
module pcmp_check #(
   parameter int unsigned LANES  = 3,
   parameter int unsigned LANE_W = 8
) (
   input logic [LANES*LANE_W-1:0] a_i,
   input logic [LANES*LANE_W-1:0] b_i,
   input logic [1:0]              op_i,
   input logic [LANES-2:0]        split_i,
   input logic [LANES-1:0]        res_o
);
   logic known;
   assign known = !$isunknown({a_i, b_i, op_i, split_i});

   always_comb begin
      if (known) begin
         AST_RSV_ZERO: assert (op_i != 2'b11 || res_o == '0)
            else $error("reserved op gave nonzero result"); // R9
         if (split_i == '0) begin
            AST_WIDE_EQ: assert (op_i != 2'b00 || res_o == {LANES{a_i == b_i}})
               else $error("merged equality mismatch"); // R5
            AST_WIDE_GE: assert (op_i != 2'b10 || res_o == {LANES{a_i >= b_i}})
               else $error("merged ge mismatch"); // R4
         end
         if (split_i == '1) begin
            for (int i = 0; i < LANES; i++) begin
               AST_LANE_GT: assert (op_i != 2'b01 ||
                  res_o[i] == (a_i[i*LANE_W +: LANE_W] > b_i[i*LANE_W +: LANE_W]))
                  else $error("split lane gt mismatch"); // R7
            end
         end
         for (int j = 0; j < LANES - 1; j++) begin
            AST_GROUP_SAME: assert (split_i[j] || res_o[j] == res_o[j+1])
               else $error("joined lanes disagree"); // R6
         end
      end
   end
endmodule

bind pcmp_top pcmp_check #(.LANES(LANES), .LANE_W(LANE_W)) u_pcmp_check (
   .a_i     (a_i),
   .b_i     (b_i),
   .op_i    (op_i),
   .split_i (split_i),
   .res_o   (res_o)
);

// File: tb/pcmp_top_test.sv
`timescale 1ns/1ps
module pcmp_top_test;
   localparam int N = 3;
   localparam int W = 8 * N;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] a, b;
   logic [1:0]   op;
   logic [N-2:0] split;
   logic [N-1:0] res;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   pcmp_top #(.LANES(N), .LANE_W(8)) uut (
      .a_i(a), .b_i(b), .op_i(op), .split_i(split), .res_o(res)
   );

   function automatic logic [N-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [1:0] o, input logic [N-2:0] s);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         int lo = i;
         int hi = i;
         logic [W-1:0] gx = '0;
         logic [W-1:0] gy = '0;
         while (lo > 0 && !s[lo-1]) lo--;
         while (hi < N - 1 && !s[hi]) hi++;
         for (int k = hi; k >= lo; k--) begin
            gx = (gx << 8) | W'(x[k*8 +: 8]);
            gy = (gy << 8) | W'(y[k*8 +: 8]);
         end
         case (o)
            2'b00:   r[i] = (gx == gy);
            2'b01:   r[i] = (gx > gy);
            2'b10:   r[i] = (gx >= gy);
            default: r[i] = 1'b0;
         endcase
      end
      return r;
   endfunction

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [1:0] o, input logic [N-2:0] s);
      @(negedge clk);
      a = x; b = y; op = o; split = s;
      #1;
   endtask

   task automatic check(input string req, input logic [N-1:0] exp);
      checks++;
      if (res !== exp) begin
         fails++;
         $display("FAIL %s a=%h b=%h op=%b split=%b got=%b exp=%b",
                  req, a, b, op, split, res, exp);
      end
   endtask

   task automatic t_reset;
      apply('0, '0, 2'b00, '0);
      check("R2 reset equal", 3'b111);
   endtask

   task automatic t_merged;
      apply(24'h123456, 24'h123455, 2'b01, 2'b00);
      check("R5 wide gt", 3'b111);
      apply(24'h010000, 24'h00FFFF, 2'b01, 2'b00);
      check("R6 msb lane dominates", 3'b111);
      apply(24'h00FFFF, 24'h010000, 2'b10, 2'b00);
      check("R5 wide ge false", 3'b000);
   endtask

   task automatic t_split;
      apply(24'h0510FF, 24'h061000, 2'b01, 2'b11);
      check("R7 per-lane gt", 3'b001);
      apply(24'h0510FF, 24'h061000, 2'b10, 2'b11);
      check("R7 per-lane ge", 3'b011);
      apply(24'h0510FF, 24'h061000, 2'b00, 2'b11);
      check("R1 per-lane eq", 3'b010);
   endtask

   task automatic t_three;
      apply(24'h010005, 24'h00FF09, 2'b01, 2'b01);
      check("R8 upper pair joined", 3'b110);
      apply(24'h010005, 24'h00FF09, 2'b01, 2'b10);
      check("R8 lower pair joined", 3'b100);
   endtask

   task automatic t_ops;
      apply(24'hA5A5A5, 24'hA5A5A5, 2'b00, 2'b01);
      check("R2 equal operands", 3'b111);
      apply(24'hA5A5A5, 24'hA5A5A5, 2'b01, 2'b01);
      check("R3 equal operands gt", 3'b000);
      apply(24'hA5A5A5, 24'hA5A5A5, 2'b10, 2'b01);
      check("R4 equal operands ge", 3'b111);
   endtask

   task automatic t_reserved;
      apply(24'hFF0000, 24'h000000, 2'b11, 2'b00);
      check("R9 reserved merged", 3'b000);
      apply(24'h123456, 24'h123456, 2'b11, 2'b11);
      check("R9 reserved split", 3'b000);
   endtask

   task automatic t_comb;
      apply(24'h000001, 24'h000000, 2'b01, 2'b11);
      #1 a = 24'h000000;
      #1 check("R10 no clock needed", 3'b000);
   endtask

   task automatic t_random;
      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] x, y;
         x = W'($urandom);
         y = W'($urandom);
         if (n % 3 == 0) y[15:8] = x[15:8];
         if (n % 5 == 0) y[23:16] = x[23:16];
         apply(x, y, 2'($urandom), (N-1)'($urandom));
         check("R6 random groups", model(x, y, op, split));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; op = '0; split = '0;
      t_reset();
      t_merged();
      t_split();
      t_three();
      t_ops();
      t_reserved();
      t_comb();
      t_random();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule